// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Tracker

This block watches the stream of retired instructions and makes sure that every tracked indirect call or indirect jump lands on a landing-pad marker instruction. When such a branch retires, the block arms a tracker. The next instruction retired at the same privilege level must then be the marker that belongs to the current operand mode. If it is anything else, the block raises a control-protection fault, together with an error code, in the same cycle as that retire.

There are two independent trackers, one for user privilege and one for supervisor privilege. Only the tracker selected by the privilege flag of the retiring instruction can change. The other one keeps its state, so a branch left pending at one level is still enforced when execution comes back to that level. Indirect branches that carry the no-track prefix are exempt. Relative and conditional branches are never tracked.

The retire port gives, for each instruction, its class, the no-track flag, its first four bytes, the mode flag and the privilege flag. The block compares the bytes against the marker for the current mode and needs no other decoding.

Top module: `lpad_guard`

## Requirements
- R1: After reset both trackers are idle. A first retire of a non-marker instruction at either privilege level then raises no fault, and `cp_code` reads zero.
- R2: A retire with `rt_class` = 1 (indirect call or jump) and `rt_notrack` = 0 arms the tracker of the retire's privilege level.
- R3: When the tracker is armed and the next retire at that level carries the correct marker, no fault is raised and the tracker returns to idle.
- R4: When the tracker is armed and the next retire at that level carries anything other than the correct marker (this includes another indirect branch), `cp_fault` is high in that same cycle and the tracker returns to idle.
- R5: The marker depends on the mode. With `rt_wide` = 1 it is bytes F3 0F 1E FA, and with `rt_wide` = 0 it is F3 0F 1E FB. Byte k of the instruction sits in `rt_bytes[8k+7:8k]`, so the two markers are the words 32'hFA1E0FF3 and 32'hFB1E0FF3. A marker of the other mode counts as a wrong instruction.
- R6: An indirect branch with `rt_notrack` = 1 leaves the tracker idle.
- R7: Retires with `rt_class` 0 (other), 2 (relative call/jump or conditional jump) or 3 (treated as other) never arm a tracker.
- R8: Only the tracker selected by `rt_user` (1 = user, 0 = supervisor) changes on a retire. The other tracker keeps its state across privilege changes.
- R9: `cp_fault` is high only in a cycle with `rt_valid` high. Cycles without a retire leave both trackers unchanged.
- R10: `cp_code` equals the parameter `FAULT_CODE` (default 3) while `cp_fault` is high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rt_valid | input | 1 | One instruction retires this cycle |
| rt_class | input | 2 | 0 other, 1 indirect call/jump, 2 relative or conditional branch, 3 other |
| rt_notrack | input | 1 | Instruction carries the no-track prefix |
| rt_bytes | input | 32 | First four instruction bytes, byte 0 in bits 7:0 |
| rt_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| rt_user | input | 1 | 1 = user privilege, 0 = supervisor |
| cp_fault | output | 1 | Control-protection fault for this retire |
| cp_code | output | CODE_W | Error code, valid while cp_fault is high |

## Verification
On every cycle the assertions check that a fault appears only with a retire, that the code tracks the fault flag, that a fault or any armed-state retire leaves the selected tracker idle, that an untracked branch never arms, and that the unselected tracker does not change. Whether a particular byte pattern counts as the marker for each mode, and whether a pending branch survives a privilege round trip, can only be shown by the bench's scenarios. Those scenarios observe it through the fault output on a later retire.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER    = 2'd0,
    CLS_INDIRECT = 2'd1,
    CLS_RELATIVE = 2'd2,
    CLS_OTHER3   = 2'd3
  } rt_class_e;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;

  localparam int unsigned NUM_LEVELS = 2;   // index 0 supervisor, 1 user
  localparam int unsigned MARK_BYTES = 4;
  localparam int unsigned MARK_W     = 8 * MARK_BYTES;
  localparam logic [23:0] MARK_HEAD  = 24'h1E0FF3; // bytes 0..2, little order
  localparam logic [7:0]  MARK_TAIL64 = 8'hFA;
  localparam logic [7:0]  MARK_TAIL32 = 8'hFB;
endpackage

// File: rtl/lpad_rst_sync.sv
module lpad_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpad_marker_match.sv
module lpad_marker_match
  import lpad_pkg::*;
(
  input  logic [MARK_W-1:0] bytes_i,
  input  logic              wide_i,
  output logic              match_o
);
  logic [7:0] tail_want;

  always_comb begin
    tail_want = wide_i ? MARK_TAIL64 : MARK_TAIL32;
    match_o   = (bytes_i[23:0] == MARK_HEAD) && (bytes_i[31:24] == tail_want);
  end
endmodule

// File: rtl/lpad_tracker.sv
module lpad_tracker
  import lpad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,       // a retire at this tracker's level
  input  logic arm_i,        // retire is a tracked indirect branch
  input  logic pad_ok_i,     // retire carries the correct marker
  output logic waiting_o,
  output logic viol_o
);
  trk_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    state_en = step_i;
    viol_o   = 1'b0;
    unique case (state_q)
      TRK_IDLE: if (arm_i) state_d = TRK_WAIT;
      TRK_WAIT: begin
        state_d = TRK_IDLE;
        viol_o  = step_i && !pad_ok_i;
      end
      default: state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= TRK_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign waiting_o = (state_q == TRK_WAIT);
endmodule

// File: rtl/lpad_guard.sv
module lpad_guard
  import lpad_pkg::*;
#(
  parameter int unsigned CODE_W     = 16,
  parameter int unsigned FAULT_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic [1:0]        rt_class,
  input  logic              rt_notrack,
  input  logic [31:0]       rt_bytes,
  input  logic              rt_wide,
  input  logic              rt_user,
  output logic              cp_fault,
  output logic [CODE_W-1:0] cp_code
);
  localparam logic [CODE_W-1:0] CODE_VAL = CODE_W'(FAULT_CODE);

  logic                  rst_n_int;
  logic                  pad_ok;
  logic                  arm;
  logic [NUM_LEVELS-1:0] step;
  logic [NUM_LEVELS-1:0] waiting;
  logic [NUM_LEVELS-1:0] viol;

  lpad_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  lpad_marker_match u_match (
    .bytes_i(rt_bytes), .wide_i(rt_wide), .match_o(pad_ok)
  );

  assign arm = (rt_class == CLS_INDIRECT) && !rt_notrack;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    assign step[g] = rt_valid && (rt_user == g[0]);
    lpad_tracker u_trk (
      .clk(clk), .rst_n(rst_n_int),
      .step_i(step[g]), .arm_i(arm), .pad_ok_i(pad_ok),
      .waiting_o(waiting[g]), .viol_o(viol[g])
    );
  end

  assign cp_fault = |viol;
  assign cp_code  = cp_fault ? CODE_VAL : '0;
endmodule

// File: rtl/lpad_guard_chk.sv
module lpad_guard_chk #(
  parameter int unsigned CODE_W     = 16,
  parameter int unsigned FAULT_CODE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rt_valid,
  input logic [1:0]        rt_class,
  input logic              rt_notrack,
  input logic              rt_user,
  input logic              cp_fault,
  input logic [CODE_W-1:0] cp_code,
  input logic              sup_wait,
  input logic              usr_wait
);
  p_fault_needs_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault |-> rt_valid);

  p_code_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault |-> cp_code == CODE_W'(FAULT_CODE));

  p_code_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cp_fault |-> cp_code == '0);

  p_arm_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_user && !usr_wait && rt_class == 2'd1 && !rt_notrack) |=> usr_wait);

  p_notrack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_user && !usr_wait && rt_notrack) |=> !usr_wait);

  p_rel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && !rt_user && !sup_wait && rt_class != 2'd1) |=> !sup_wait);

  p_wait_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_user && usr_wait) |=> !usr_wait);

  p_sup_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_user) |=> sup_wait == $past(sup_wait));

  p_usr_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && !rt_user) |=> usr_wait == $past(usr_wait));

  p_fault_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fault |-> (rt_user ? usr_wait : sup_wait));
endmodule

bind lpad_guard lpad_guard_chk #(.CODE_W(CODE_W), .FAULT_CODE(FAULT_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_class(rt_class),
  .rt_notrack(rt_notrack), .rt_user(rt_user), .cp_fault(cp_fault),
  .cp_code(cp_code), .sup_wait(waiting[0]), .usr_wait(waiting[1])
);

// File: tb/test_lpad_guard.sv
module test_lpad_guard;
  localparam int CODE_W = 16;
  localparam logic [31:0] PAD64 = 32'hFA1E0FF3;
  localparam logic [31:0] PAD32 = 32'hFB1E0FF3;
  localparam logic [31:0] JUNK  = 32'h90909090;

  logic clk = 1'b0;
  logic rst_n;
  logic rt_valid, rt_notrack, rt_wide, rt_user;
  logic [1:0] rt_class;
  logic [31:0] rt_bytes;
  logic cp_fault;
  logic [CODE_W-1:0] cp_code;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpad_guard #(.CODE_W(CODE_W), .FAULT_CODE(3)) i_lpad_guard (
    .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_class(rt_class),
    .rt_notrack(rt_notrack), .rt_bytes(rt_bytes), .rt_wide(rt_wide),
    .rt_user(rt_user), .cp_fault(cp_fault), .cp_code(cp_code)
  );

  task automatic check(input string req, input logic exp_fault);
    logic [CODE_W-1:0] exp_code;
    exp_code = exp_fault ? CODE_W'(3) : '0;
    checks++;
    if (cp_fault !== exp_fault || cp_code !== exp_code) begin
      errors++;
      $display("FAIL %s: fault=%0b code=%0d expected fault=%0b code=%0d",
               req, cp_fault, cp_code, exp_fault, exp_code);
    end
  endtask

  // drive one retire after a falling edge, check combinational result, hold through next rising edge
  task automatic retire(input logic [1:0] cls, input logic nt, input logic [31:0] b,
                        input logic wide, input logic user, input logic exp_fault,
                        input string req);
    @(negedge clk);
    rt_valid = 1'b1; rt_class = cls; rt_notrack = nt; rt_bytes = b;
    rt_wide = wide; rt_user = user;
    #5 check(req, exp_fault);
    @(negedge clk);
    rt_valid = 1'b0; rt_class = 2'd0; rt_bytes = JUNK;
  endtask

  task automatic t_reset;
    check("R1 idle port", 1'b0);
    retire(2'd0, 0, JUNK, 1, 1, 0, "R1 user idle");
    retire(2'd0, 0, JUNK, 1, 0, 0, "R1 sup idle");
  endtask

  task automatic t_good_pad;
    retire(2'd1, 0, JUNK, 1, 1, 0, "R2 arm");
    retire(2'd0, 0, PAD64, 1, 1, 0, "R3 pad64 ok");
    retire(2'd0, 0, JUNK, 1, 1, 0, "R3 back to idle");
  endtask

  task automatic t_bad_target;
    retire(2'd1, 0, JUNK, 1, 1, 0, "R2 arm");
    retire(2'd0, 0, JUNK, 1, 1, 1, "R4 R10 bad target");
    retire(2'd0, 0, JUNK, 1, 1, 0, "R4 idle after fault");
    retire(2'd1, 0, JUNK, 1, 0, 0, "R2 arm sup");
    retire(2'd1, 0, JUNK, 1, 0, 1, "R4 branch on branch");
    retire(2'd0, 0, JUNK, 1, 0, 0, "R4 idle after fault");
  endtask

  task automatic t_modes;
    retire(2'd1, 0, JUNK, 0, 1, 0, "R5 arm 32");
    retire(2'd0, 0, PAD64, 0, 1, 1, "R5 pad64 in 32-bit");
    retire(2'd1, 0, JUNK, 0, 1, 0, "R5 arm 32");
    retire(2'd0, 0, PAD32, 0, 1, 0, "R5 pad32 in 32-bit");
    retire(2'd1, 0, JUNK, 1, 1, 0, "R5 arm 64");
    retire(2'd0, 0, PAD32, 1, 1, 1, "R5 pad32 in 64-bit");
  endtask

  task automatic t_notrack;
    retire(2'd1, 1, JUNK, 1, 1, 0, "R6 notrack");
    retire(2'd0, 0, JUNK, 1, 1, 0, "R6 still idle");
  endtask

  task automatic t_untracked;
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      retire(2'(c), 0, JUNK, 1, 0, 0, "R7 class");
      retire(2'd0, 0, JUNK, 1, 0, 0, "R7 not armed");
    end
  endtask

  task automatic t_priv_split;
    retire(2'd1, 0, JUNK, 1, 1, 0, "R8 arm user");
    retire(2'd0, 0, JUNK, 1, 0, 0, "R8 sup unaffected");
    retire(2'd1, 0, JUNK, 1, 0, 0, "R8 arm sup");
    retire(2'd0, 0, JUNK, 1, 1, 1, "R8 user kept waiting");
    retire(2'd0, 0, PAD64, 1, 0, 0, "R8 sup kept waiting, pad ok");
    retire(2'd0, 0, JUNK, 1, 0, 0, "R8 sup idle");
  endtask

  task automatic t_gap;
    retire(2'd1, 0, JUNK, 1, 1, 0, "R9 arm");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rt_bytes = JUNK;
      #5 check("R9 no retire no fault", 1'b0);
    end
    retire(2'd0, 0, JUNK, 1, 1, 1, "R9 state held over gap");
  endtask

  initial begin
    rst_n = 1'b0; rt_valid = 1'b0; rt_class = 2'd0; rt_notrack = 1'b0;
    rt_bytes = JUNK; rt_wide = 1'b1; rt_user = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_good_pad();
    t_bad_target();
    t_modes();
    t_notrack();
    t_untracked();
    t_priv_split();
    t_gap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule